// File: doc/BRIEF.md
# Waveform sample buffer with in-band event marking

This block keeps the most recent 2000 byte-wide converter samples in a circular memory that a display engine reads back. An asynchronous event pulse is recorded in the data itself. The next sample written after the pulse is replaced by a reserved code word, 8'hFF. Real samples of that value are clamped to 8'hFE so that the code stays unique. During readback the display stream watches for the code word. Each time it appears, the block raises blanking for that one sample, which marks the event instant on the trace.

A single read port serves two streams in turn, a display stream and a delayed stream. The display stream walks forward from a base location. The base moves one location on every frame start, so the picture scrolls. The delayed stream reads the location the writer will overwrite next, which is the oldest sample. The blank output combines the marker blanking with the retrace blanking from the timing generator. A hold input freezes the picture: while it is high, writes are ignored, the scroll base stays put, the delayed stream is silenced and marker blanking is suppressed. Retrace blanking still passes through during hold.

Top module: `trace_marker_buffer`

## Requirements
- R1: After reset, disp_vld and dly_vld are 0, blank equals retrace_blank, and the write pointer, scroll base and display pointer are all 0. The first read after reset is a display read.
- R2: When hold is low, a wr_stb cycle stores the sample at the write pointer and then advances the pointer. The pointer wraps from 1999 to 0, so the 2001st write replaces the first one.
- R3: A sample equal to 8'hFF is stored as 8'hFE. Every other sample value is stored unchanged.
- R4: A rising edge on marker_in is passed through a two-stage synchronizer and then arms a pending flag. The next accepted write stores 8'hFF instead of its sample and clears the flag. One pulse of any width gives exactly one substituted sample.
- R5: Each rd_stb performs one read, and reads alternate display, delayed, display, and so on. The data appears on rd_data one cycle after the rd_stb cycle. In that same cycle disp_vld is high for a display read, or dly_vld is high for a delayed read.
- R6: A display read that returns 8'hFF while hold is low drives blank high for exactly the cycle in which disp_vld is high.
- R7: blank is high in every cycle in which retrace_blank is high, and this includes cycles with hold high.
- R8: While hold is high, wr_stb has no effect on memory or on the write pointer. A display read of 8'hFF does not raise blank. A delayed read produces no dly_vld.
- R9: On frame_start, the scroll base advances by one location, wrapping from 1999 to 0, unless hold is high. The display pointer reloads to the resulting base, and the next read is a display read.
- R10: A delayed read returns the word at the current write pointer, which is the oldest stored sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Converter sample strobe |
| wr_data | input | 8 | Converter sample |
| marker_in | input | 1 | Asynchronous event pulse |
| hold | input | 1 | Freeze the picture |
| frame_start | input | 1 | Start of a display frame, which advances the scroll |
| rd_stb | input | 1 | Read slot request |
| retrace_blank | input | 1 | Retrace blanking from the timing generator |
| rd_data | output | 8 | Read data, shared by both streams |
| disp_vld | output | 1 | rd_data holds a display sample |
| dly_vld | output | 1 | rd_data holds a delayed-stream sample |
| blank | output | 1 | Trace blanking |

## Verification
The hardest case to reach is a marker code that sits at a known address, where a display read meets it both with hold low and with hold high. Getting there takes a full 2000-sample fill, a wrap, a synchronized marker pulse and a scroll step, all without any internal access. The bench keeps a model memory and model pointers. It fills and wraps the buffer, pulses the marker, and steps frames so that the code lands within a few display slots of the base. It then replays the same reads under hold and checks that the data and valid strobes still match while blank stays low. A write issued under hold is read back afterwards through the delayed stream, which shows that the write did not take effect.

// File: rtl/trace_marker_buffer.sv
module trace_marker_buffer #(
  parameter int DEPTH = 2000,
  parameter int DW = 8,
  parameter logic [DW-1:0] MARK_CODE = '1,
  parameter logic [DW-1:0] CLAMP_VAL = MARK_CODE - 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic          marker_in,
  input  logic          hold,
  input  logic          frame_start,
  input  logic          rd_stb,
  input  logic          retrace_blank,
  output logic [DW-1:0] rd_data,
  output logic          disp_vld,
  output logic          dly_vld,
  output logic          blank
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, base, disp_ptr, rd_addr, base_nx;
  logic [2:0]    msync;
  logic          pend, slot, mk_blank, wr_ok, mk_rise;
  logic [DW-1:0] wr_word;

  assign mk_rise = msync[1] & ~msync[2];
  assign wr_ok   = wr_stb & ~hold;
  assign wr_word = pend ? MARK_CODE : (wr_data == MARK_CODE ? CLAMP_VAL : wr_data);
  assign rd_addr = slot ? wr_ptr : disp_ptr;
  assign base_nx = hold ? base : step(base);
  assign blank   = retrace_blank | mk_blank;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msync <= '0;
      pend  <= 1'b0;
    end else begin
      msync <= {msync[1:0], marker_in};
      pend  <= (pend & ~wr_ok) | mk_rise;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wr_ptr <= '0;
    else if (wr_ok) wr_ptr <= step(wr_ptr);
  end

  always_ff @(posedge clk)
    if (wr_ok) mem[wr_ptr] <= wr_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base     <= '0;
      disp_ptr <= '0;
      slot     <= 1'b0;
    end else if (frame_start) begin
      base     <= base_nx;
      disp_ptr <= base_nx;
      slot     <= 1'b0;
    end else if (rd_stb) begin
      slot <= ~slot;
      if (!slot) disp_ptr <= step(disp_ptr);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      disp_vld <= 1'b0;
      dly_vld  <= 1'b0;
      mk_blank <= 1'b0;
    end else begin
      if (rd_stb) rd_data <= mem[rd_addr];
      disp_vld <= rd_stb & ~slot;
      dly_vld  <= rd_stb & slot & ~hold;
      mk_blank <= rd_stb & ~slot & ~hold & (mem[rd_addr] == MARK_CODE);
    end
  end

  // R2
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_ptr <= LAST);
  // R8
  hold_wr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n) hold |=> $stable(wr_ptr));
  // R9
  hold_base_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n) hold |=> $stable(base));
  // R5
  one_stream_chk: assert property (@(posedge clk) disable iff (!rst_n) !(disp_vld && dly_vld));
  // R6
  mark_blank_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !slot && !hold && !frame_start) |=> (disp_vld && (blank == (retrace_blank || rd_data == MARK_CODE))));
  // R8
  dly_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) hold |=> !dly_vld);
  // R7
  retrace_pass_chk: assert property (@(posedge clk) disable iff (!rst_n) retrace_blank |-> blank);
endmodule

// File: tb/test_trace_marker_buffer.sv
module test_trace_marker_buffer;
  logic clk = 0, rst_n = 0, wr_stb = 0, marker_in = 0, hold = 0;
  logic frame_start = 0, rd_stb = 0, retrace_blank = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic disp_vld, dly_vld, blank;
  int checks = 0, errors = 0;

  trace_marker_buffer i_trace_marker_buffer (.*);

  always #5 clk = ~clk;

  logic [7:0] mdl [2000];
  int wptr = 0, base = 0, dptr = 0, slot = 0, pend = 0;
  logic [9:0] q [$];
  bit done = 0;

  function automatic int inc(int p); return (p == 1999) ? 0 : p + 1; endfunction

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(posedge clk); #1 wr_stb = 1; wr_data = d;
    @(posedge clk); #1 wr_stb = 0;
    if (!hold) begin
      mdl[wptr] = pend ? 8'hFF : (d == 8'hFF ? 8'hFE : d);
      pend = 0;
      wptr = inc(wptr);
    end
  endtask

  task automatic rd();
    int a;
    logic [7:0] v;
    if (slot == 0) begin a = dptr; dptr = inc(dptr); end else a = wptr;
    v = mdl[a];
    if (slot == 0) q.push_back({v, 1'b0, (v == 8'hFF) && !hold});
    else if (!hold) q.push_back({v, 1'b1, 1'b0});
    slot ^= 1;
    @(posedge clk); #1 rd_stb = 1;
    @(posedge clk); #1 rd_stb = 0;
  endtask

  task automatic frame();
    if (!hold) base = inc(base);
    dptr = base; slot = 0;
    @(posedge clk); #1 frame_start = 1;
    @(posedge clk); #1 frame_start = 0;
  endtask

  task automatic marker(int width);
    @(posedge clk); #1 marker_in = 1;
    repeat (width) @(posedge clk);
    #1 marker_in = 0;
    repeat (4) @(posedge clk);
    pend = 1;
  endtask

  // monitor
  always @(negedge clk) if (rst_n && !done) begin
    logic exp_mb;
    logic [9:0] it;
    exp_mb = 0;
    if (disp_vld || dly_vld) begin
      if (q.size() == 0) chk("R5 unexpected read result", 1, 0);
      else begin
        it = q.pop_front();
        chk("R5/R10 read data", rd_data, it[9:2]);
        chk("R5 stream kind dly_vld", dly_vld, it[1]);
        exp_mb = it[0];
      end
    end
    chk("R6/R7/R8 blank", blank, retrace_blank | exp_mb);
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 disp_vld after reset", disp_vld, 0);
    chk("R1 dly_vld after reset", dly_vld, 0);
    chk("R1 blank after reset", blank, 0);
    retrace_blank = 1; #1;
    chk("R7 blank in reset follows retrace", blank, 1);
    retrace_blank = 0;
    @(posedge clk); #1 rst_n = 1;
    // R2 R3: fill with ramp (255 is clamped), then wrap
    for (int i = 0; i < 2000; i++) wr(8'(i));
    for (int i = 0; i < 5; i++) wr(8'(8'h10 + i));
    // R4: wide marker pulse gives one substituted sample at address 5
    marker(3);
    wr(8'h55); wr(8'h66); wr(8'hFF);
    // R10 R5 R6: base 1, display addresses 1..6, marker at 5
    frame();
    for (int i = 0; i < 12; i++) rd();
    // R8: hold
    @(posedge clk); #1 hold = 1;
    wr(8'h42);
    frame();
    for (int i = 0; i < 12; i++) rd();
    retrace_blank = 1;
    @(negedge clk);
    chk("R7 retrace blank during hold", blank, 1);
    @(posedge clk); #1 retrace_blank = 0;
    hold = 0;
    // R9: base now 2; reads include delayed slot at wptr (shows write under hold dropped)
    frame();
    for (int i = 0; i < 8; i++) rd();
    // R4: second marker with narrow pulse
    marker(1);
    wr(8'h77); wr(8'h78);
    base = 7; // scroll so display starts just before new marker
    repeat (5) begin
      @(posedge clk); #1 frame_start = 1;
      @(posedge clk); #1 frame_start = 0;
    end
    dptr = base; slot = 0;
    for (int i = 0; i < 6; i++) rd();
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R5 all expected reads returned", q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule